// File: doc/BRIEF.md
# Successive-Approximation Converter Register Controller

This block sits between a byte-wide CPU register port and an external 10-bit successive-approximation converter front end. Software programs a mode byte that picks the conversion speed, whether an external trigger pin may start a conversion, and which of sixteen analog channels to convert. A conversion is started either by writing a start bit or, when enabled, by a rising edge on the trigger pin.

Each conversion lasts a fixed number of system clocks: 62 in normal speed and 31 in fast speed. During that time the block drives a trial word to the DAC and comparator, which sit outside the block, and decides one result bit at a time from the most significant bit down, based on the comparator answer. At the end it latches the 10-bit word into a pair of read-only result bytes, clears the start bit and raises a completion flag. The result bytes are deliberately left out of reset, so a value survives a reset pulse.

CPU register map (2-bit address): 0 = result high byte, 1 = result low byte, 2 = mode, 3 = control.

Top module: `adc_regctl`

## Requirements
- R1: After reset the mode register (address 2) reads 0x30, the control register (address 3) reads 0x00 and busy_o is 0.
- R2: Mode bits 5 and 4 always read 1 and ignore writes; bit 7 (fast speed), bit 6 (trigger enable) and bits 3:0 (channel) read back as written.
- R3: Writing address 3 with bit 7 set while idle starts a conversion on the next clock edge; busy_o and control bit 7 read 1 while it runs.
- R4: busy_o stays high for exactly 62 clock cycles when mode bit 7 is 0 and for exactly 31 cycles when it is 1.
- R5: Each conversion starts with trial_o = 0x200 and resolves bits 9 down to 0; a bit stays set only when cmp_i is 1 while it is tried, so a comparator answering "input at or above trial" yields the input code.
- R6: Address 0 reads result bits 9:2; address 1 reads result bits 1:0 in its bits 7:6, with bits 5:0 reading 0.
- R7: When the result is latched, control bit 7 clears and control bit 6 (done) sets; done clears when the next conversion starts.
- R8: The result bytes keep their value until the next conversion latches a new one, also while that conversion runs; writes to addresses 0 and 1 have no effect.
- R9: The result bytes are not cleared by reset.
- R10: With mode bit 6 set, a rising edge on ext_trig_i (synchronised through two flip-flops) starts a conversion; with bit 6 clear the pin has no effect.
- R11: Start writes and trigger edges that arrive while a conversion runs are ignored: the conversion keeps its length and no further conversion follows.
- R12: chan_o takes mode bits 3:0 when a conversion starts and holds them for the whole conversion, even if the mode register is rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | CPU register address |
| bus_wr_i | input | 1 | CPU write strobe, one cycle per write |
| bus_wdata_i | input | 8 | CPU write data |
| bus_rdata_o | output | 8 | CPU read data for bus_addr_i (combinational) |
| ext_trig_i | input | 1 | Asynchronous external start trigger |
| cmp_i | input | 1 | Comparator answer: 1 when analog input is at or above the trial level |
| trial_o | output | 10 | Trial word for the DAC |
| chan_o | output | 4 | Channel being converted |
| busy_o | output | 1 | Conversion in progress |

## Verification
The assertions assume cmp_i is a synchronous, settled answer to the current trial_o and that the result is only relied on after at least one conversion has completed since power-up, since the result bytes are never reset. The bench models the comparator as a direct digital compare of trial_o against a held input code, changes that code only while the block is idle, and drives the trigger pin at negedges with long enough highs and lows for the two-flop synchroniser to see every edge.

// File: rtl/adc_regctl_pkg.sv
package adc_regctl_pkg;

   typedef enum logic [1:0] {
      ADDR_RES_HI = 2'd0,
      ADDR_RES_LO = 2'd1,
      ADDR_MODE   = 2'd2,
      ADDR_CTRL   = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_trig_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
   parameter int RES_W    = 10,
   parameter int CH_W     = 4,
   parameter int SLOW_CYC = 62,
   parameter int FAST_CYC = 31
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fast_i,
   input  logic [CH_W-1:0]  chan_i,
   input  logic             cmp_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] trial_o,
   output logic [RES_W-1:0] result_o,
   output logic [CH_W-1:0]  chan_o
);

   localparam int CNT_W     = $clog2(SLOW_CYC);
   localparam int SLOW_STEP = SLOW_CYC / RES_W;
   localparam int FAST_STEP = FAST_CYC / RES_W;
   localparam int STEP_W    = $clog2(SLOW_STEP + 1);
   localparam int IDX_W     = $clog2(RES_W);
   localparam int LEFT_W    = $clog2(RES_W + 1);
   localparam logic [CNT_W-1:0]  SLOW_LAST  = CNT_W'(SLOW_CYC - 1);
   localparam logic [CNT_W-1:0]  FAST_LAST  = CNT_W'(FAST_CYC - 1);
   localparam logic [STEP_W-1:0] SLOW_SLAST = STEP_W'(SLOW_STEP - 1);
   localparam logic [STEP_W-1:0] FAST_SLAST = STEP_W'(FAST_STEP - 1);
   localparam logic [RES_W-1:0]  TRIAL_INIT = RES_W'(1) << (RES_W - 1);

   if (FAST_CYC > SLOW_CYC) begin : g_bad_order
      $error("adc_sar_engine: FAST_CYC must not exceed SLOW_CYC");
   end
   if (FAST_STEP < 1 || FAST_STEP * RES_W >= FAST_CYC) begin : g_bad_fast
      $error("adc_sar_engine: FAST_CYC too short for RES_W decisions");
   end
   if (SLOW_STEP * RES_W >= SLOW_CYC) begin : g_bad_slow
      $error("adc_sar_engine: SLOW_CYC too short for RES_W decisions");
   end

   logic              busy_q, fast_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [STEP_W-1:0] step_q;
   logic [IDX_W-1:0]  idx_q;
   logic [LEFT_W-1:0] left_q;
   logic [RES_W-1:0]  sar_q, result_q;
   logic [CH_W-1:0]   chan_q;

   logic last_cyc, step_end, decide;
   assign last_cyc = cnt_q == (fast_q ? FAST_LAST : SLOW_LAST);
   assign step_end = step_q == (fast_q ? FAST_SLAST : SLOW_SLAST);
   assign decide   = busy_q && step_end && (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fast_q <= 1'b0;
         cnt_q  <= '0;
         step_q <= '0;
         idx_q  <= '0;
         left_q <= '0;
         sar_q  <= '0;
         chan_q <= '0;
      end else if (!busy_q) begin
         if (start_i) begin
            busy_q <= 1'b1;
            fast_q <= fast_i;
            cnt_q  <= '0;
            step_q <= '0;
            idx_q  <= IDX_W'(RES_W - 1);
            left_q <= LEFT_W'(RES_W);
            sar_q  <= TRIAL_INIT;
            chan_q <= chan_i;
         end
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         step_q <= step_end ? '0 : step_q + 1'b1;
         if (decide) begin
            sar_q[idx_q] <= cmp_i;
            if (idx_q != '0) sar_q[idx_q - 1'b1] <= 1'b1;
            idx_q  <= idx_q - 1'b1;
            left_q <= left_q - 1'b1;
         end
         if (last_cyc) busy_q <= 1'b0;
      end
   end

   // result deliberately has no reset
   always_ff @(posedge clk) begin
      if (busy_q && last_cyc) result_q <= sar_q;
   end

   assign busy_o   = busy_q;
   assign done_o   = busy_q && last_cyc;
   assign trial_o  = sar_q;
   assign result_o = result_q;
   assign chan_o   = chan_q;

   AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> cnt_q <= (fast_q ? FAST_LAST : SLOW_LAST)); // R4
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !last_cyc |=> busy_q && cnt_q == $past(cnt_q) + 1'b1); // R11
   AST_TRIAL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> trial_o == TRIAL_INIT); // R5
   AST_ALL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && last_cyc |-> left_q == '0); // R5
   AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> $stable(chan_o)); // R12

endmodule

// File: rtl/adc_regctl.sv
module adc_regctl
   import adc_regctl_pkg::*;
#(
   parameter int RES_W       = 10,
   parameter int DATA_W      = 8,
   parameter int CH_W        = 4,
   parameter int SLOW_CYC    = 62,
   parameter int FAST_CYC    = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   input  logic              ext_trig_i,
   input  logic              cmp_i,
   output logic [RES_W-1:0]  trial_o,
   output logic [CH_W-1:0]   chan_o,
   output logic              busy_o
);

   localparam int LOW_W   = RES_W - DATA_W;
   localparam int RSVD_W  = DATA_W - 2 - CH_W;
   localparam int SPD_BIT = DATA_W - 1;
   localparam int TRG_BIT = DATA_W - 2;

   if (LOW_W < 1 || LOW_W > DATA_W) begin : g_bad_res
      $error("adc_regctl: RES_W must exceed DATA_W by 1 to DATA_W bits");
   end
   if (RSVD_W < 1) begin : g_bad_ch
      $error("adc_regctl: CH_W leaves no reserved mode bits");
   end

   logic            speed_q, trge_q, done_q;
   logic [CH_W-1:0] ch_q;
   logic            trig_rise, sw_start, start_req, eng_busy, eng_done;
   logic [RES_W-1:0] result;
   logic [DATA_W-1:0] res_hi, res_lo, mode_rd, ctrl_rd;

   adc_trig_sync #(.STAGES(SYNC_STAGES)) trig_i (
      .clk(clk), .rst_n(rst_n), .async_i(ext_trig_i), .rise_o(trig_rise)
   );

   assign sw_start  = bus_wr_i && (bus_addr_i == ADDR_CTRL) && bus_wdata_i[SPD_BIT];
   assign start_req = !eng_busy && (sw_start || (trge_q && trig_rise));

   adc_sar_engine #(
      .RES_W(RES_W), .CH_W(CH_W), .SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)
   ) eng_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_req), .fast_i(speed_q),
      .chan_i(ch_q), .cmp_i(cmp_i), .busy_o(eng_busy), .done_o(eng_done),
      .trial_o(trial_o), .result_o(result), .chan_o(chan_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speed_q <= 1'b0;
         trge_q  <= 1'b0;
         ch_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         if (bus_wr_i && bus_addr_i == ADDR_MODE) begin
            speed_q <= bus_wdata_i[SPD_BIT];
            trge_q  <= bus_wdata_i[TRG_BIT];
            ch_q    <= bus_wdata_i[CH_W-1:0];
         end
         if (eng_done)       done_q <= 1'b1;
         else if (start_req) done_q <= 1'b0;
      end
   end

   assign res_hi = result[RES_W-1 -: DATA_W];
   if (LOW_W < DATA_W) begin : g_lo_pad
      assign res_lo = {result[LOW_W-1:0], {(DATA_W-LOW_W){1'b0}}};
   end else begin : g_lo_full
      assign res_lo = result[LOW_W-1:0];
   end

   assign mode_rd = {speed_q, trge_q, {RSVD_W{1'b1}}, ch_q};
   assign ctrl_rd = {eng_busy, done_q, {(DATA_W-2){1'b0}}};

   always_comb begin
      unique case (reg_addr_e'(bus_addr_i))
         ADDR_RES_HI: bus_rdata_o = res_hi;
         ADDR_RES_LO: bus_rdata_o = res_lo;
         ADDR_MODE:   bus_rdata_o = mode_rd;
         default:     bus_rdata_o = ctrl_rd;
      endcase
   end

   logic wdata_unused;
   assign wdata_unused = ^bus_wdata_i;
   assign busy_o = eng_busy;

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_busy) |-> done_q); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && $past(done_q) |-> $stable(result)); // R8
   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |=> !$rose(done_q) || !eng_busy); // R11

endmodule

// File: tb/adc_regctl_tb_top.sv
`timescale 1ns/1ps
module adc_regctl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ext_trig = 1'b0;
   logic       cmp;
   logic [9:0] trial, vin = 10'h000;
   logic [3:0] chan;
   logic       busy;
   int         checks = 0, failures = 0, busy_cyc = 0;
   bit         finished = 0;

   always #2 clk = ~clk;

   adc_regctl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_wr_i(bus_wr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .ext_trig_i(ext_trig),
      .cmp_i(cmp), .trial_o(trial), .chan_o(chan), .busy_o(busy)
   );

   assign cmp = (trial <= vin);

   always @(posedge clk) if (busy) busy_cyc <= busy_cyc + 1;

   // {fast, channel, input code}
   localparam logic [14:0] VECS [6] = '{
      {1'b0, 4'd3,  10'h000}, {1'b1, 4'd9,  10'h3FF}, {1'b0, 4'd0,  10'h2AA},
      {1'b1, 4'd15, 10'h155}, {1'b1, 4'd6,  10'h001}, {1'b0, 4'd12, 10'h3FE}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 200 && busy; i++) @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(2, d); chk("R1 mode", d, 8'h30);
      rd(3, d); chk("R1 ctrl", d, 8'h00);
      chk("R1 busy", busy, 0);
      // R2 reserved bits
      wr(2, 8'h00); rd(2, d); chk("R2 clear", d, 8'h30);
      wr(2, 8'hCF); rd(2, d); chk("R2 set", d, 8'hFF);
      wr(2, 8'h05); rd(2, d); chk("R2 mixed", d, 8'h35);

      // vector walk: R3 R4 R5 R6 R7 R12
      foreach (VECS[k]) begin
         logic       f;
         logic [3:0] c;
         f = VECS[k][14]; c = VECS[k][13:10];
         vin = VECS[k][9:0];
         wr(2, {f, 3'b000, c});
         busy_cyc = 0;
         wr(3, 8'h80);
         chk("R3 busy", busy, 1);
         rd(3, d); chk("R3/R7 ctrl busy", d, 8'h80);
         chk("R12 chan", chan, c);
         chk("R5 trial init", trial, 10'h200);
         wait_idle();
         chk("R4 length", busy_cyc, f ? 31 : 62);
         rd(0, d); chk("R5/R6 hi", d, vin[9:2]);
         rd(1, d); chk("R6 lo", d, {vin[1:0], 6'b0});
         rd(3, d); chk("R7 done", d, 8'h40);
      end

      // R8 hold and read-only
      vin = 10'h2C7;
      wr(0, 8'h00); wr(1, 8'hFF);
      rd(0, d); chk("R8 hi ro", d, 8'hFF);
      rd(1, d); chk("R8 lo ro", d, 8'h80);
      wr(2, 8'h85); wr(3, 8'h80);
      idle(10);
      rd(0, d); chk("R8 hold busy", d, 8'hFF);
      // R12 mode rewrite mid-conversion
      wr(2, 8'h8A);
      chk("R12 chan held", chan, 4'd5);
      wait_idle();
      rd(0, d); chk("R8 new hi", d, 8'hB1);
      rd(1, d); chk("R8 new lo", d, 8'hC0);
      wr(3, 8'h80);
      chk("R12 next chan", chan, 4'hA);
      wait_idle();

      // R10 trigger disabled
      wr(2, 8'h80);
      ext_trig = 1'b1; idle(4); ext_trig = 1'b0; idle(8);
      chk("R10 ignored", busy, 0);
      // R10 trigger enabled
      vin = 10'h0F3;
      wr(2, 8'hC2);
      busy_cyc = 0;
      ext_trig = 1'b1;
      for (int i = 0; i < 10 && !busy; i++) @(negedge clk);
      chk("R10 started", busy, 1);
      ext_trig = 1'b0;
      wait_idle();
      chk("R10 length", busy_cyc, 31);
      rd(0, d); chk("R10 hi", d, 8'h3C);

      // R11 start events during a conversion
      idle(4);
      busy_cyc = 0;
      wr(3, 8'h80);
      idle(4); ext_trig = 1'b1;
      idle(4); wr(3, 8'h80);
      wait_idle();
      chk("R11 length", busy_cyc, 31);
      idle(10);
      chk("R11 no restart", busy, 0);
      ext_trig = 1'b0;

      // R9 result survives reset
      idle(2);
      rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
      rd(0, d); chk("R9 hi kept", d, 8'h3C);
      rd(1, d); chk("R9 lo kept", d, 8'hC0);
      rd(2, d); chk("R1 mode again", d, 8'h30);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule